// File: doc/BRIEF.md
# Divided Countdown Timer

The block is the local timer of an interrupt controller. A base clock enable is slowed by a programmable power-of-two prescaler, and each resulting tick steps a 32-bit down-counter. Software programs three registers through a single write port: the initial count, a divide configuration, and a control word. The control word carries the interrupt vector, a mask bit and a mode bit that picks one-shot or periodic operation.

Writing the initial count loads the counter and restarts both the prescaler and the count from that cycle. The live count is always visible on `cur_count_o`. When the count runs out, the block raises `expire_o` for one clock cycle and presents the programmed vector on `expire_vec_o` in the same cycle. Interrupt delivery and priority handling sit outside the block.

In one-shot mode, expiry happens once per load. In periodic mode, the counter reloads itself and expiry repeats. The count keeps advancing while the timer is masked, so unmasking never shifts the phase.

Top module: `cdt_timer`

## Requirements
- R1: After reset, `ctrl_o` reads 0x00010000 (masked, one-shot, vector 0). `div_cfg_o`, `init_count_o` and `cur_count_o` read 0, and `expire_o` is low.
- R2: A write with `wr_sel_i`=1 stores the data ANDed with 0xB into the divide configuration, so only bits 3, 1 and 0 are kept and every other bit reads 0.
- R3: The divide code is {cfg[3], cfg[1], cfg[0]} and the tick shift is (code+1) mod 8. A tick occurs on every 2^shift-th base enable counted from the last initial-count write. Examples: cfg 0xB gives divide by 1, cfg 0 gives divide by 2, cfg 3 gives 16, cfg 8 gives 32 and cfg 0xA gives 128.
- R4: A write with `wr_sel_i`=0 makes `cur_count_o` equal to the written value from the next cycle. It clears the prescaler and re-arms a one-shot timer, and any expiry still pending from the earlier load is dropped.
- R5: In one-shot mode (control bit 17 = 0), the count drops by one per tick down to 0 and then holds 0. Expiry fires once, on the tick that brings the elapsed ticks to initial+1.
- R6: In periodic mode (control bit 17 = 1), the tick that finds the count at 0 reloads the initial value and fires expiry, giving one expiry every initial+1 ticks. An initial count of 0 never fires.
- R7: While control bit 16 is set, no expiry is produced but the count keeps advancing. A one-shot expiry that falls inside a masked interval is consumed and does not fire later.
- R8: `expire_o` is high for exactly one cycle, one cycle after the expiring tick. In that cycle `expire_vec_o` equals control bits 7:0.
- R9: A control-word write takes effect on the following ticks without touching the count phase. After a one-shot has expired, selecting periodic mode makes the count read the running period position, and expiry fires at the next wrap.
- R10: While `base_en_i` is low, neither the prescaler nor the count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_en_i | input | 1 | Base time enable feeding the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | 0 initial count, 1 divide configuration, 2 control word |
| wr_data_i | input | 32 | Write data |
| init_count_o | output | 32 | Initial count register |
| div_cfg_o | output | 32 | Divide configuration register |
| ctrl_o | output | 32 | Control word register |
| cur_count_o | output | 32 | Live current count |
| expire_o | output | 1 | One-cycle expiry pulse |
| expire_vec_o | output | 8 | Vector presented with the expiry pulse |

## Verification
A wrong prescaler phase or a wrong shift decode moves every expiry pulse by whole tick periods, so the bench pins each pulse to an exact cycle rather than only counting pulses.

A one-shot done flag that is stuck or lost shows up in two ways: as a second pulse, or as a non-zero count after expiry, at the first wrap after the first expiry. That first wrap comes within initial+1 ticks.

If the masked path or the mode switch loses the period phase, the count read mid-period is off, and the first pulse after unmasking lands in the wrong cycle. The bench checks both within one period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int SHIFT_W       = 3;
  localparam int CTRL_MASK_BIT = 16;
  localparam int CTRL_PER_BIT  = 17;
  localparam logic [3:0]  DIV_KEEP = 4'hB;
  localparam logic [31:0] CTRL_RST = 32'h0001_0000;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // code bits come from cfg[1:0] and cfg[3]; shift wraps so code 7 divides by 1
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SHIFT_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int VEC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [REG_W-1:0]   wr_data_i,
  output logic [REG_W-1:0]   init_o,
  output logic [REG_W-1:0]   div_o,
  output logic [REG_W-1:0]   ctrl_o,
  output logic               load_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               periodic_o,
  output logic               masked_o,
  output logic [VEC_W-1:0]   vec_o
);
  reg_sel_e sel;
  logic [REG_W-1:0] init_q, div_q, ctrl_q;

  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      div_q  <= '0;
      ctrl_q <= REG_W'(CTRL_RST);
    end else if (wr_en_i) begin
      case (sel)
        SEL_INIT: init_q <= wr_data_i;
        SEL_DIV:  div_q  <= {{(REG_W-4){1'b0}}, wr_data_i[3:0] & DIV_KEEP};
        SEL_CTRL: ctrl_q <= wr_data_i;
        default:  ;
      endcase
    end
  end

  assign load_o     = wr_en_i && (sel == SEL_INIT);
  assign shift_o    = div_shift(div_q[3:0]);
  assign periodic_o = ctrl_q[CTRL_PER_BIT];
  assign masked_o   = ctrl_q[CTRL_MASK_BIT];
  assign vec_o      = ctrl_q[VEC_W-1:0];
  assign init_o     = init_q;
  assign div_o      = div_q;
  assign ctrl_o     = ctrl_q;

  assert_div_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel == SEL_DIV) |=> (div_q == (($past(wr_data_i)) & REG_W'(DIV_KEEP))));

  assert_ctrl_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && sel == SEL_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
#(
  parameter int PRE_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               base_en_i,
  input  logic               clear_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign low_mask[g] = (SHIFT_W'(g) < shift_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (clear_i)   pre_q <= '0;
    else if (base_en_i) pre_q <= pre_q + PRE_W'(1);
  end

  assign tick_o = base_en_i && ((pre_q & low_mask) == low_mask);

  // after a restart with shift>0 the first base enable never ticks
  assert_first_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && shift_i != '0) |=> !tick_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!base_en_i && !clear_i) |=> $stable(pre_q));
endmodule

// File: rtl/cdt_core.sv
module cdt_core #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             masked_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [CNT_W-1:0] cur_count_o,
  output logic             expire_o,
  output logic [VEC_W-1:0] expire_vec_o
);
  logic [CNT_W-1:0] ph_q;
  logic             done_q, exp_q;
  logic [VEC_W-1:0] vec_q;
  logic             ph_zero, fire;

  assign ph_zero = (ph_q == '0);
  // one-shot fires only on its first wrap; periodic needs a non-zero period
  assign fire    = !masked_i && (periodic_i ? (|init_i) : !done_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      done_q <= 1'b0;
      exp_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      exp_q <= 1'b0;
      if (load_i) begin
        ph_q   <= load_val_i;
        done_q <= 1'b0;
      end else if (tick_i) begin
        if (ph_zero) begin
          ph_q   <= init_i;
          done_q <= 1'b1;
          if (fire) begin
            exp_q <= 1'b1;
            vec_q <= vec_i;
          end
        end else begin
          ph_q <= ph_q - CNT_W'(1);
        end
      end
    end
  end

  assign cur_count_o  = (!periodic_i && done_q) ? '0 : ph_q;
  assign expire_o     = exp_q;
  assign expire_vec_o = vec_q;

  assert_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ph_q == $past(load_val_i)) && !done_q && !expire_o);

  assert_step_down_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !ph_zero) |=> (ph_q == $past(ph_q) - CNT_W'(1)));

  assert_phase_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= init_i);

  assert_zero_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (!$past(periodic_i) || $past(init_i) != '0));

  assert_masked_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !$past(masked_i));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);

  assert_pulse_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (expire_vec_o == $past(vec_i)));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] init_count_o,
  output logic [REG_W-1:0] div_cfg_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] cur_count_o,
  output logic             expire_o,
  output logic [VEC_W-1:0] expire_vec_o
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic               load, tick, periodic, masked;
  logic [SHIFT_W-1:0] shift;
  logic [VEC_W-1:0]   vec;

  cdt_regs #(.REG_W(REG_W), .VEC_W(VEC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .init_o     (init_count_o),
    .div_o      (div_cfg_o),
    .ctrl_o     (ctrl_o),
    .load_o     (load),
    .shift_o    (shift),
    .periodic_o (periodic),
    .masked_o   (masked),
    .vec_o      (vec)
  );

  cdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .base_en_i (base_en_i),
    .clear_i   (load),
    .shift_i   (shift),
    .tick_o    (tick)
  );

  cdt_core #(.CNT_W(REG_W), .VEC_W(VEC_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_val_i   (wr_data_i),
    .init_i       (init_count_o),
    .tick_i       (tick),
    .periodic_i   (periodic),
    .masked_i     (masked),
    .vec_i        (vec),
    .cur_count_o  (cur_count_o),
    .expire_o     (expire_o),
    .expire_vec_o (expire_vec_o)
  );
endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n, base_en, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [31:0] init_count, div_cfg, ctrl, cur_count;
  logic        expire;
  logic [7:0]  expire_vec;

  always #10 clk = ~clk;

  cdt_timer u_cdt_timer (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .base_en_i    (base_en),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .init_count_o (init_count),
    .div_cfg_o    (div_cfg),
    .ctrl_o       (ctrl),
    .cur_count_o  (cur_count),
    .expire_o     (expire),
    .expire_vec_o (expire_vec)
  );

  typedef struct {
    int         at;
    logic [7:0] vec;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int at, input logic [7:0] v, input string req);
    exp_t e;
    e.at = at; e.vec = v; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int p);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    p = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected pulses and compares cycle and vector
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (sb_q.size() > 0 && sb_q[0].at < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: missing pulse, actual none expected at cycle %0d", sb_q[0].req, sb_q[0].at);
        void'(sb_q.pop_front());
      end
      if (expire) begin
        n_cmp++;
        if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
          if (expire_vec !== sb_q[0].vec) begin
            n_bad++;
            $display("FAIL %s: vector actual 0x%02h expected 0x%02h", sb_q[0].req, expire_vec, sb_q[0].vec);
          end
          void'(sb_q.pop_front());
        end else begin
          n_bad++;
          $display("FAIL R8: unexpected pulse, actual at cycle %0d expected none", cyc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int p, q, dummy;
    rst_n = 1'b0; base_en = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl, 32'h0001_0000);
    check("R1 div", div_cfg, 32'h0);
    check("R1 init", init_count, 32'h0);
    check("R1 count", cur_count, 32'h0);
    check("R1 expire", {31'd0, expire}, 32'h0);

    // R2 divide config keeps bits 3,1,0
    wr(2'd1, 32'hFFFF_FFFF, dummy);
    check("R2 keep", div_cfg, 32'hB);
    wr(2'd1, 32'h0000_0004, dummy);
    check("R2 drop", div_cfg, 32'h0);

    // R5 one-shot, R4 restart mid-count
    wr(2'd1, 32'hB, dummy);
    wr(2'd2, 32'h21, dummy);
    wr(2'd0, 32'd5, p);
    wait_to(p + 2);
    check("R5 count", cur_count, 32'd3);
    wait_to(p + 3);
    wr(2'd0, 32'd5, q);
    push(q + 6, 8'h21, "R4");
    check("R4 load", cur_count, 32'd5);
    wait_to(q + 1);
    check("R4 restart", cur_count, 32'd4);
    wait_to(q + 6);
    check("R5 zero", cur_count, 32'd0);
    wait_to(q + 7);
    check("R8 one cycle", {31'd0, expire}, 32'h0);
    wait_to(q + 20);
    check("R5 hold", cur_count, 32'd0);

    // R3 divider decode
    wr(2'd1, 32'h0, dummy);
    wr(2'd0, 32'd3, p);
    push(p + 8, 8'h21, "R3 div2");
    wait_to(p + 5);
    check("R3 div2 count", cur_count, 32'd1);
    wait_to(p + 9);
    wr(2'd1, 32'h3, dummy);
    wr(2'd0, 32'd1, p);
    push(p + 32, 8'h21, "R3 div16");
    wait_to(p + 15);
    check("R3 div16 count", cur_count, 32'd1);
    wait_to(p + 33);
    wr(2'd1, 32'h8, dummy);
    wr(2'd0, 32'd0, p);
    push(p + 32, 8'h21, "R3 div32");
    wait_to(p + 33);
    wr(2'd1, 32'hA, dummy);
    wr(2'd0, 32'd0, p);
    push(p + 128, 8'h21, "R3 div128");
    wait_to(p + 129);
    wr(2'd1, 32'hB, dummy);

    // R6 periodic, R7 masked continues
    wr(2'd2, 32'h0003_0042, dummy);
    wr(2'd0, 32'd2, p);
    wr(2'd2, 32'h0002_0042, dummy);
    push(p + 3, 8'h42, "R6 p1");
    push(p + 6, 8'h42, "R6 p2");
    push(p + 9, 8'h42, "R6 p3");
    push(p + 15, 8'h42, "R7 unmask");
    wait_to(p + 4);
    check("R6 count", cur_count, 32'd1);
    wait_to(p + 9);
    wr(2'd2, 32'h0003_0042, dummy);
    wait_to(p + 13);
    check("R7 count runs", cur_count, 32'd1);
    wr(2'd2, 32'h0002_0042, dummy);
    wait_to(p + 16);
    wr(2'd2, 32'h0003_0042, dummy);
    // R6 zero initial count never fires
    wr(2'd0, 32'd0, q);
    wr(2'd2, 32'h0002_0042, dummy);
    wait_to(q + 20);
    check("R6 zero count", cur_count, 32'd0);
    wr(2'd2, 32'h0001_0000, dummy);

    // R7 masked one-shot expiry is consumed
    wr(2'd2, 32'h0001_0033, dummy);
    wr(2'd0, 32'd2, p);
    wait_to(p + 4);
    wr(2'd2, 32'h33, dummy);
    wait_to(p + 15);
    check("R7 consumed", cur_count, 32'd0);

    // R9 mode switch after one-shot expiry
    wr(2'd2, 32'h55, dummy);
    wr(2'd0, 32'd3, p);
    push(p + 4, 8'h55, "R5 once");
    wait_to(p + 6);
    check("R9 one-shot holds", cur_count, 32'd0);
    wr(2'd2, 32'h0002_0055, dummy);
    push(p + 8, 8'h55, "R9 wrap");
    wait_to(p + 9);
    check("R9 phase", cur_count, 32'd2);
    wr(2'd2, 32'h0001_0055, dummy);

    // R10 base enable low freezes the timer
    wr(2'd2, 32'h66, dummy);
    wr(2'd0, 32'd4, p);
    base_en = 1'b0;
    wait_to(p + 11);
    check("R10 frozen", cur_count, 32'd4);
    base_en = 1'b1;
    push(p + 16, 8'h66, "R10 resume");
    wait_to(p + 13);
    check("R10 resumed", cur_count, 32'd2);
    wait_to(p + 20);

    done = 1'b1;
    while (sb_q.size() > 0) begin
      n_cmp++; n_bad++;
      $display("FAIL %s: missing pulse, actual none expected at cycle %0d", sb_q[0].req, sb_q[0].at);
      void'(sb_q.pop_front());
    end
    summary();
    $finish;
  end
endmodule